// File: doc/BRIEF.md
# Edge-Triggered Timestamp Capture Unit

The block stamps external events with the value of a free-running counter. One of two event inputs is chosen: a digital pin or the output of an analog comparator. The chosen input passes through a two-flop synchroniser. A change of level whose direction matches the programmed polarity is an event. On each event the full counter value is copied into a capture register, and a capture flag is set in that same clock.

The flag drives an interrupt request when the interrupt enable is high. The flag is cleared by an interrupt acknowledge pulse, or by a write strobe that carries a one. A new event always overwrites the capture register, even while the flag is still set.

Software reads the capture register over an 8-bit bus, low byte first. Reading the low byte copies the high byte into a shadow register. A later high-byte read returns that shadow copy, so the two bytes belong to the same event.

Top module: `evt_capture_unit`

## Requirements
- R1: `src_sel` = 0 selects `pin_in` and `src_sel` = 1 selects `cmp_in`. Level changes on the input that is not selected cause no capture.
- R2: With `edge_rise` = 1 only a low-to-high change on the selected input is an event. With `edge_rise` = 0 only a high-to-low change is an event.
- R3: Suppose the selected input takes a new level that is first sampled at clock edge k, and this change is an event. At edge k+2 the capture register loads the `cnt_value` present just before that edge. This value is all 16 bits.
- R4: The capture flag is set at the same clock edge at which the capture register loads.
- R5: `irq_req` is high exactly when the capture flag is set and `irq_en` is 1.
- R6: `irq_ack` high at a clock edge clears the capture flag.
- R7: `flag_wr` with `flag_wdata` = 1 clears the capture flag. `flag_wr` with `flag_wdata` = 0 leaves it unchanged.
- R8: If a capture and a clear (acknowledge or write of one) fall on the same edge, the flag ends up set.
- R9: An event while the flag is set overwrites the capture register with the new counter value, and the flag stays set.
- R10: With `rd_en` = 1, `rd_addr` = 0 returns capture bits 7:0 on `rd_data` and, at that edge, copies bits 15:8 into the shadow register. `rd_addr` = 1 returns the shadow register. With `rd_en` = 0, `rd_data` is 0.
- R11: After reset the capture register, the shadow register and the flag are 0, and `irq_req` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | External event pin (asynchronous) |
| cmp_in | input | 1 | Comparator output event (asynchronous) |
| src_sel | input | 1 | Event source: 0 pin, 1 comparator |
| edge_rise | input | 1 | Polarity: 1 rising, 0 falling |
| cnt_value | input | 16 | Free-running counter value to stamp |
| irq_en | input | 1 | Capture interrupt enable |
| irq_ack | input | 1 | Interrupt serviced; clears the flag |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 1 | Flag write data; 1 clears |
| rd_en | input | 1 | Capture register read strobe |
| rd_addr | input | 1 | Byte select: 0 low, 1 high (shadow) |
| rd_data | output | 8 | Read data |
| cap_flag | output | 1 | Capture flag |
| irq_req | output | 1 | Interrupt request |

## Verification
The capture path is driven in several ways:
- Single rising and single falling pulses in both polarity settings. These separate a correct edge match from a detector that fires on any level change.
- Toggling the pin and the comparator in turn while one of them is selected. This shows whether the selection really gates the events.
- Events that follow each other with the flag left set, and an event placed in the same cycle as an acknowledge. These test overwrite and the set-over-clear priority.

Byte reads are separated by an event that moves the counter's high byte. A correct shadow register then returns the old high byte, where a direct read would return the new one.

// File: rtl/cap_pkg.sv
package cap_pkg;

  typedef enum logic {
    SRC_PIN = 1'b0,
    SRC_CMP = 1'b1
  } cap_src_e;

  typedef enum logic {
    BYTE_LO = 1'b0,
    BYTE_HI = 1'b1
  } cap_byte_e;

  // Event when the synchronised level changed and the new level equals
  // the requested polarity (1 = rising, 0 = falling).
  function automatic logic edge_hit(input logic prev_lvl,
                                    input logic cur_lvl,
                                    input logic rise);
    return (prev_lvl != cur_lvl) && (cur_lvl == rise);
  endfunction

  // Next flag state: a new capture has priority over any clear source.
  function automatic logic flag_next(input logic cur,
                                     input logic set_evt,
                                     input logic ack,
                                     input logic wr_one);
    if (set_evt)          return 1'b1;
    else if (ack || wr_one) return 1'b0;
    else                  return cur;
  endfunction

endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  input  logic cmp_in,
  input  logic src_sel,
  input  logic edge_rise,
  output logic lvl_now,
  output logic lvl_prev,
  output logic evt
);
  import cap_pkg::*;

  localparam int LAST = STAGES - 1;

  logic             src_raw;
  logic [LAST:0]    sync_q;
  logic             prev_q;

  assign src_raw = (cap_src_e'(src_sel) == SRC_CMP) ? cmp_in : pin_in;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= src_raw;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[i] <= 1'b0;
          else        sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[LAST];
  end

  assign lvl_now  = sync_q[LAST];
  assign lvl_prev = prev_q;
  assign evt      = edge_hit(prev_q, sync_q[LAST], edge_rise);

endmodule

// File: rtl/cap_store.sv
module cap_store #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic [CNT_W-1:0] cnt_value,
  input  logic             irq_en,
  input  logic             irq_ack,
  input  logic             wr_one,
  output logic [CNT_W-1:0] cap_value,
  output logic             flag,
  output logic             irq
);
  import cap_pkg::*;

  logic [CNT_W-1:0] cap_q;
  logic             flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   cap_q <= '0;
    else if (evt) cap_q <= cnt_value;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_next(flag_q, evt, irq_ack, wr_one);
  end

  assign cap_value = cap_q;
  assign flag      = flag_q;
  assign irq       = flag_q & irq_en;

endmodule

// File: rtl/cap_reader.sv
module cap_reader #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             rd_addr,
  input  logic [CNT_W-1:0] cap_value,
  output logic [BUS_W-1:0] rd_data,
  output logic [BUS_W-1:0] shadow
);
  import cap_pkg::*;

  localparam int HI_LSB = BUS_W;
  localparam int HI_MSB = CNT_W - 1;

  logic [BUS_W-1:0] shadow_q;
  logic             lo_read;

  assign lo_read = rd_en && (cap_byte_e'(rd_addr) == BYTE_LO);

  always_ff @(posedge clk) begin
    if (!rst_n)       shadow_q <= '0;
    else if (lo_read) shadow_q <= cap_value[HI_MSB:HI_LSB];
  end

  always_comb begin
    if (!rd_en)       rd_data = '0;
    else if (lo_read) rd_data = cap_value[BUS_W-1:0];
    else              rd_data = shadow_q;
  end

  assign shadow = shadow_q;

endmodule

// File: rtl/evt_capture_unit.sv
module evt_capture_unit #(
  parameter int CNT_W  = 16,
  parameter int BUS_W  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_in,
  input  logic             cmp_in,
  input  logic             src_sel,
  input  logic             edge_rise,
  input  logic [CNT_W-1:0] cnt_value,
  input  logic             irq_en,
  input  logic             irq_ack,
  input  logic             flag_wr,
  input  logic             flag_wdata,
  input  logic             rd_en,
  input  logic             rd_addr,
  output logic [BUS_W-1:0] rd_data,
  output logic             cap_flag,
  output logic             irq_req
);

  logic             lvl_now;
  logic             lvl_prev;
  logic             cap_evt;
  logic             wr_one;
  logic [CNT_W-1:0] cap_value;
  logic [BUS_W-1:0] shadow_hi;

  assign wr_one = flag_wr & flag_wdata;

  cap_sync_edge #(.STAGES(STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .cmp_in   (cmp_in),
    .src_sel  (src_sel),
    .edge_rise(edge_rise),
    .lvl_now  (lvl_now),
    .lvl_prev (lvl_prev),
    .evt      (cap_evt)
  );

  cap_store #(.CNT_W(CNT_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (cap_evt),
    .cnt_value(cnt_value),
    .irq_en   (irq_en),
    .irq_ack  (irq_ack),
    .wr_one   (wr_one),
    .cap_value(cap_value),
    .flag     (cap_flag),
    .irq      (irq_req)
  );

  cap_reader #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_read (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .cap_value(cap_value),
    .rd_data  (rd_data),
    .shadow   (shadow_hi)
  );

endmodule

// File: rtl/evt_capture_chk.sv
module evt_capture_chk #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cap_evt,
  input logic             lvl_now,
  input logic             edge_rise,
  input logic [CNT_W-1:0] cnt_value,
  input logic [CNT_W-1:0] cap_value,
  input logic             cap_flag,
  input logic             irq_req,
  input logic             irq_ack,
  input logic             flag_wr,
  input logic             flag_wdata,
  input logic             rd_en,
  input logic             rd_addr,
  input logic [BUS_W-1:0] shadow_hi
);

  // R2: an event only ever reports the programmed new level
  assert_polarity_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |-> (lvl_now == edge_rise));

  // R3: the capture register holds the counter seen at the capture edge
  assert_stamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_value == $past(cnt_value)));

  // R3: without an event the capture register keeps its value
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(cap_value));

  // R4 and R8: a capture always leaves the flag set
  assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_flag);

  // R5: no request without the flag
  assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> cap_flag);

  // R6: acknowledge clears when nothing new is captured
  assert_ack_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !cap_evt) |=> !cap_flag);

  // R7: a write of zero leaves the flag as it is
  assert_wr_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && !flag_wdata && !irq_ack && !cap_evt) |=> $stable(cap_flag));

  // R10: a low-byte read latches the high byte
  assert_shadow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_addr) |=> (shadow_hi == $past(cap_value[CNT_W-1:BUS_W])));

endmodule

bind evt_capture_unit evt_capture_chk #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cap_evt   (cap_evt),
  .lvl_now   (lvl_now),
  .edge_rise (edge_rise),
  .cnt_value (cnt_value),
  .cap_value (cap_value),
  .cap_flag  (cap_flag),
  .irq_req   (irq_req),
  .irq_ack   (irq_ack),
  .flag_wr   (flag_wr),
  .flag_wdata(flag_wdata),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .shadow_hi (shadow_hi)
);

// File: tb/tb_evt_capture_unit.sv
`timescale 1ns/100ps
module tb_evt_capture_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_in = 1'b0, cmp_in = 1'b0, src_sel = 1'b0, edge_rise = 1'b1;
  logic [15:0] cnt_value = 16'hFF00;
  logic        irq_en = 1'b0, irq_ack = 1'b0, flag_wr = 1'b0, flag_wdata = 1'b0;
  logic        rd_en = 1'b0, rd_addr = 1'b0;
  logic [7:0]  rd_data;
  logic        cap_flag, irq_req;

  int    n_tests = 0;
  int    n_fail  = 0;
  string phase   = "R11";

  always #2.5 clk = ~clk;

  evt_capture_unit dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cmp_in(cmp_in),
    .src_sel(src_sel), .edge_rise(edge_rise), .cnt_value(cnt_value),
    .irq_en(irq_en), .irq_ack(irq_ack), .flag_wr(flag_wr),
    .flag_wdata(flag_wdata), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .cap_flag(cap_flag), .irq_req(irq_req)
  );

  // free-running counter, updated shortly after each edge
  always @(posedge clk) begin
    #0.5 cnt_value = cnt_value + 16'd1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          hist[$];
  logic [15:0] m_cap;
  logic        m_flag;
  logic [7:0]  m_shadow;
  bit          m_evt;

  always @(posedge clk) begin
    if (!rst_n) begin
      hist     = '{1'b0, 1'b0, 1'b0};
      m_cap    = '0;
      m_flag   = 1'b0;
      m_shadow = '0;
    end else begin
      // hist[0]: level sampled one edge ago, hist[1]: two ago, hist[2]: three ago
      m_evt = (hist[1] != hist[2]) && (hist[1] == edge_rise);
      if (rd_en && !rd_addr) m_shadow = m_cap[15:8];
      if (m_evt) begin
        m_cap  = cnt_value;
        m_flag = 1'b1;
      end else if (irq_ack || (flag_wr && flag_wdata)) begin
        m_flag = 1'b0;
      end
      hist.push_front(src_sel ? cmp_in : pin_in);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] exp_rd;
      exp_rd = !rd_en ? 8'h00 : (rd_addr ? m_shadow : m_cap[7:0]);
      chk(cap_flag == m_flag, {"R4/", phase}, "flag", cap_flag, m_flag);
      chk(irq_req == (m_flag && irq_en), {"R5/", phase}, "irq",
          irq_req, m_flag && irq_en);
      chk(rd_data == exp_rd, {"R10/", phase}, "rd_data", rd_data, exp_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic read_word(output logic [15:0] w);
    tick(); rd_en = 1'b1; rd_addr = 1'b0;
    @(negedge clk); w[7:0] = rd_data;
    tick(); rd_addr = 1'b1;
    @(negedge clk); w[15:8] = rd_data;
    tick(); rd_en = 1'b0; rd_addr = 1'b0;
  endtask

  logic [15:0] c0, w, old_cap;
  logic [7:0]  lo_b, hi_b;

  initial begin
    #(200000 * 5);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick();
    // R11: reset state
    phase = "R11";
    rd_en = 1'b1; rd_addr = 1'b0; irq_en = 1'b1;
    @(negedge clk);
    chk(cap_flag == 1'b0, "R11", "flag after reset", cap_flag, 0);
    chk(irq_req == 1'b0, "R11", "irq after reset", irq_req, 0);
    chk(rd_data == 8'h00, "R11", "low byte after reset", rd_data, 0);
    tick(); rd_addr = 1'b1;
    @(negedge clk);
    chk(rd_data == 8'h00, "R11", "shadow after reset", rd_data, 0);
    tick(); rd_en = 1'b0; rd_addr = 1'b0;

    // R3: rising pin event, latency and full value
    phase = "R3";
    src_sel = 1'b0; edge_rise = 1'b1;
    tick(); c0 = cnt_value; pin_in = 1'b1;
    tick(6);
    chk(cap_flag == 1'b1, "R4", "flag after rise", cap_flag, 1);
    chk(irq_req == 1'b1, "R5", "irq with enable", irq_req, 1);
    read_word(w);
    chk(w == c0 + 16'd2, "R3", "captured value", w, c0 + 16'd2);

    // R7: write zero keeps, write one clears
    phase = "R7";
    flag_wr = 1'b1; flag_wdata = 1'b0; tick(); flag_wr = 1'b0; tick();
    chk(cap_flag == 1'b1, "R7", "flag after write 0", cap_flag, 1);
    flag_wr = 1'b1; flag_wdata = 1'b1; tick(); flag_wr = 1'b0; flag_wdata = 1'b0; tick();
    chk(cap_flag == 1'b0, "R7", "flag after write 1", cap_flag, 0);

    // R2: falling edge ignored in rising mode, captured in falling mode
    phase = "R2";
    pin_in = 1'b0; tick(6);
    chk(cap_flag == 1'b0, "R2", "fall ignored when rising", cap_flag, 0);
    edge_rise = 1'b0;
    pin_in = 1'b1; tick(6);
    chk(cap_flag == 1'b0, "R2", "rise ignored when falling", cap_flag, 0);
    c0 = cnt_value; pin_in = 1'b0; tick(6);
    chk(cap_flag == 1'b1, "R2", "fall captured", cap_flag, 1);
    read_word(w);
    chk(w == c0 + 16'd2, "R2", "falling capture value", w, c0 + 16'd2);

    // R6: acknowledge clears
    phase = "R6";
    irq_ack = 1'b1; tick(); irq_ack = 1'b0; tick();
    chk(cap_flag == 1'b0, "R6", "flag after ack", cap_flag, 0);

    // R1: comparator selected, pin activity ignored
    phase = "R1";
    src_sel = 1'b1; tick(4);
    pin_in = 1'b1; tick(4); pin_in = 1'b0; tick(6);
    chk(cap_flag == 1'b0, "R1", "pin ignored on comparator source", cap_flag, 0);
    cmp_in = 1'b1; tick(6);
    c0 = cnt_value; cmp_in = 1'b0; tick(6);
    chk(cap_flag == 1'b1, "R1", "comparator event", cap_flag, 1);
    read_word(w);
    chk(w == c0 + 16'd2, "R1", "comparator capture value", w, c0 + 16'd2);

    // R9: second event overwrites while flag set
    phase = "R9";
    cmp_in = 1'b1; tick(6);
    c0 = cnt_value; cmp_in = 1'b0; tick(6);
    read_word(w);
    chk(w == c0 + 16'd2, "R9", "overwrite value", w, c0 + 16'd2);
    chk(cap_flag == 1'b1, "R9", "flag stays set", cap_flag, 1);

    // R8: ack on the capture edge loses to the capture
    phase = "R8";
    irq_ack = 1'b1; tick(); irq_ack = 1'b0; tick();
    cmp_in = 1'b1; tick(6);
    cmp_in = 1'b0; tick(2);
    irq_ack = 1'b1; tick(); irq_ack = 1'b0; tick();
    chk(cap_flag == 1'b1, "R8", "capture beats ack", cap_flag, 1);

    // R5: enable low masks request
    phase = "R5";
    irq_en = 1'b0; tick();
    chk(irq_req == 1'b0, "R5", "irq masked", irq_req, 0);
    irq_en = 1'b1; tick();
    chk(irq_req == 1'b1, "R5", "irq unmasked", irq_req, 1);

    // R10: shadow keeps the old high byte across a new capture
    phase = "R10";
    read_word(old_cap);
    tick(); rd_en = 1'b1; rd_addr = 1'b0;
    @(negedge clk); lo_b = rd_data;
    tick(); rd_en = 1'b0;
    tick(300);
    cmp_in = 1'b1; tick(6); cmp_in = 1'b0; tick(6);
    tick(); rd_en = 1'b1; rd_addr = 1'b1;
    @(negedge clk); hi_b = rd_data;
    tick(); rd_en = 1'b0; rd_addr = 1'b0;
    chk(lo_b == old_cap[7:0], "R10", "low byte", lo_b, old_cap[7:0]);
    chk(hi_b == old_cap[15:8], "R10", "shadow high byte", hi_b, old_cap[15:8]);
    read_word(w);
    chk(w[15:8] != old_cap[15:8], "R10", "new capture high byte moved",
        w[15:8], old_cap[15:8] + 8'd1);

    tick(4);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule